// File: doc/BRIEF.md
# Packed Word Dot-Product Accumulator

This block is a vector datapath. It takes three vectors of the same width. One vector holds 32-bit accumulator lanes, and the other two hold 16-bit elements. For each 32-bit lane the block multiplies two neighbouring element pairs and adds both products to that lane's accumulator. A 2-bit mode input sets how each source is extended before the multiply: source A signed with source B unsigned, source A unsigned with source B signed, or both unsigned. A separate input chooses between wrap-around accumulation and clamped accumulation.

The vector width is fixed at elaboration to 128 bits (4 lanes) or 256 bits (8 lanes). The result bus can be wider than the active vector, and any bits above the active width read as zero. Operands are captured together with a valid bit. One clock later the result appears, together with a valid bit and a per-lane flag that shows where clamping changed the value.

Top module: `pdp_dot_acc`

## Requirements
- R1: Result lane j (bits 32j+31..32j) is built from accumulator lane j and from the 16-bit elements at indices 2j and 2j+1 of each source, where element i sits at bits 16i+15..16i.
- R2: With mode 2'b00, every A element is sign-extended and every B element is zero-extended before the multiply.
- R3: With mode 2'b01, every A element is zero-extended and every B element is sign-extended before the multiply.
- R4: With mode 2'b10, both A and B elements are zero-extended before the multiply.
- R5: With sat_en low, each lane result is (accumulator + product0 + product1) modulo 2^32, and its saturation flag is 0.
- R6: With sat_en high in mode 2'b00 or 2'b01, the accumulator is read as signed. The exact sum is clamped to the range 32'h80000000 to 32'h7FFFFFFF.
- R7: With sat_en high in mode 2'b10, the accumulator is read as unsigned. Any exact sum above 32'hFFFFFFFF becomes 32'hFFFFFFFF.
- R8: A lane's sat_flag bit is 1 exactly when clamping changed that lane's value. When the flag is set, the lane holds one of the clamp limits.
- R9: Mode 2'b11 is reserved. It yields all-zero result lanes and all-zero flags.
- R10: Result bits at and above VEC_W are always 0.
- R11: out_valid equals in_valid from the previous clock. A result is due one cycle after its operands. Reset clears out_valid and the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| mode | input | 2 | Signedness select: 00 A signed/B unsigned, 01 A unsigned/B signed, 10 both unsigned, 11 reserved |
| sat_en | input | 1 | 1 = clamped accumulation, 0 = wrap-around |
| acc_in | input | VEC_W | Accumulator lanes, 32 bits each |
| a_in | input | VEC_W | Source A, 16-bit elements |
| b_in | input | VEC_W | Source B, 16-bit elements |
| out_valid | output | 1 | res_out and sat_flag hold a fresh result |
| res_out | output | OUT_W | Result lanes; bits above VEC_W are zero |
| sat_flag | output | VEC_W/32 | Per-lane flag: clamping changed the value |

## Verification
All results (res_out, sat_flag and out_valid) come from one register stage, so each is due exactly one rising edge after the operands are presented. The bench drives operands on a falling edge and samples the outputs on the following falling edge, after the single capturing rising edge. It then drops in_valid and, in the latency scenario, checks that out_valid falls on the next falling edge. In the back-to-back scenario, new operands are driven on the same falling edge at which the previous result is sampled. This confirms that each result belongs to the operands captured one edge earlier.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
   typedef enum logic [1:0] {
      MODE_SU  = 2'b00,
      MODE_US  = 2'b01,
      MODE_UU  = 2'b10,
      MODE_RSV = 2'b11
   } pdp_mode_e;

   localparam int PDP_ELEM_W = 16;
   localparam int PDP_LANE_W = 32;
endpackage

// File: rtl/pdp_mul_pair.sv
// Extends two element pairs per mode and returns the exact sum of their products.
module pdp_mul_pair #(
   parameter int EW = pdp_pkg::PDP_ELEM_W,
   localparam int XW = EW + 1,
   localparam int PW = 2 * XW + 1
) (
   input  logic [EW-1:0]        a0,
   input  logic [EW-1:0]        a1,
   input  logic [EW-1:0]        b0,
   input  logic [EW-1:0]        b1,
   input  logic                 a_sgn,
   input  logic                 b_sgn,
   output logic signed [PW-1:0] psum
);
   logic signed [XW-1:0]   ax0, ax1, bx0, bx1;
   logic signed [2*XW-1:0] p0, p1;

   always_comb begin
      ax0  = {a_sgn & a0[EW-1], a0};
      ax1  = {a_sgn & a1[EW-1], a1};
      bx0  = {b_sgn & b0[EW-1], b0};
      bx1  = {b_sgn & b1[EW-1], b1};
      p0   = ax0 * bx0;
      p1   = ax1 * bx1;
      psum = {p0[2*XW-1], p0} + {p1[2*XW-1], p1};
   end
endmodule

// File: rtl/pdp_clamp.sv
// Chooses wrap, signed clamp, unsigned clamp or zero for one lane.
module pdp_clamp #(
   parameter int LW = pdp_pkg::PDP_LANE_W,
   parameter int SW = LW + 4
) (
   input  logic signed [SW-1:0] sum,
   input  pdp_pkg::pdp_mode_e   mode,
   input  logic                 sat_en,
   output logic [LW-1:0]        res,
   output logic                 clamped
);
   import pdp_pkg::*;

   if (SW < LW + 3) begin : g_bad_sw
      $error("pdp_clamp: SW must be at least LW+3 to hold the exact sum");
   end

   localparam logic signed [SW-1:0] SMAX = {{(SW-LW+1){1'b0}}, {(LW-1){1'b1}}};
   localparam logic signed [SW-1:0] SMIN = {{(SW-LW+1){1'b1}}, {(LW-1){1'b0}}};
   localparam logic signed [SW-1:0] UMAX = {{(SW-LW){1'b0}}, {LW{1'b1}}};

   always_comb begin
      res     = sum[LW-1:0];
      clamped = 1'b0;
      if (mode == MODE_RSV) begin
         res = '0;
      end else if (sat_en) begin
         if (mode == MODE_UU) begin
            if (sum > UMAX) begin
               res     = UMAX[LW-1:0];
               clamped = 1'b1;
            end
         end else if (sum > SMAX) begin
            res     = SMAX[LW-1:0];
            clamped = 1'b1;
         end else if (sum < SMIN) begin
            res     = SMIN[LW-1:0];
            clamped = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pdp_dot_acc.sv
module pdp_dot_acc #(
   parameter int VEC_W = 128,
   parameter int OUT_W = 256,
   parameter int EW    = pdp_pkg::PDP_ELEM_W,
   parameter int LW    = pdp_pkg::PDP_LANE_W,
   localparam int LANES = VEC_W / LW,
   localparam int PW    = 2 * (EW + 1) + 1,
   localparam int SW    = PW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       mode,
   input  logic             sat_en,
   input  logic [VEC_W-1:0] acc_in,
   input  logic [VEC_W-1:0] a_in,
   input  logic [VEC_W-1:0] b_in,
   output logic             out_valid,
   output logic [OUT_W-1:0] res_out,
   output logic [LANES-1:0] sat_flag
);
   import pdp_pkg::*;

   if (VEC_W != 128 && VEC_W != 256) begin : g_bad_vec
      $error("pdp_dot_acc: VEC_W must be 128 or 256");
   end
   if (OUT_W < VEC_W) begin : g_bad_out
      $error("pdp_dot_acc: OUT_W must not be below VEC_W");
   end
   if (LW != 2 * EW) begin : g_bad_lane
      $error("pdp_dot_acc: a lane must hold exactly two elements");
   end

   pdp_mode_e        mode_e;
   logic             a_sgn, b_sgn, acc_uns;
   logic [VEC_W-1:0] res_d;
   logic [LANES-1:0] flag_d;
   logic [VEC_W-1:0] res_q;
   logic [LANES-1:0] flag_q;

   assign mode_e  = pdp_mode_e'(mode);
   assign a_sgn   = (mode_e == MODE_SU);
   assign b_sgn   = (mode_e == MODE_US);
   assign acc_uns = (mode_e == MODE_UU);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic signed [PW-1:0] psum;
      logic signed [SW-1:0] acc_x;
      logic signed [SW-1:0] sum;
      logic [LW-1:0]        acc_l;

      assign acc_l = acc_in[j*LW +: LW];
      assign acc_x = {{(SW-LW){acc_l[LW-1] & ~acc_uns}}, acc_l};
      assign sum   = acc_x + {psum[PW-1], psum};

      pdp_mul_pair #(.EW(EW)) u_mul (
         .a0    (a_in[(2*j)*EW +: EW]),
         .a1    (a_in[(2*j+1)*EW +: EW]),
         .b0    (b_in[(2*j)*EW +: EW]),
         .b1    (b_in[(2*j+1)*EW +: EW]),
         .a_sgn (a_sgn),
         .b_sgn (b_sgn),
         .psum  (psum)
      );

      pdp_clamp #(.LW(LW), .SW(SW)) u_clamp (
         .sum     (sum),
         .mode    (mode_e),
         .sat_en  (sat_en),
         .res     (res_d[j*LW +: LW]),
         .clamped (flag_d[j])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_q     <= '0;
         flag_q    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_q  <= res_d;
            flag_q <= flag_d;
         end
      end
   end

   if (OUT_W > VEC_W) begin : g_pad
      assign res_out = {{(OUT_W-VEC_W){1'b0}}, res_q};
   end else begin : g_nopad
      assign res_out = res_q;
   end
   assign sat_flag = flag_q;

   // R11
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R11
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R9
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b11) |=> (res_out == '0 && sat_flag == '0));
   // R5
   wrap_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sat_en) |=> (sat_flag == '0));

   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      // R8
      flag_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         sat_flag[k] |-> (res_out[k*LW +: LW] == {1'b0, {(LW-1){1'b1}}} ||
                          res_out[k*LW +: LW] == {1'b1, {(LW-1){1'b0}}} ||
                          res_out[k*LW +: LW] == {LW{1'b1}}));
      // R7
      uns_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mode == 2'b10 && sat_en) |=>
            (res_out[k*LW +: LW] >= $past(acc_in[k*LW +: LW])));
   end
endmodule

// File: tb/pdp_dot_acc_bench.sv
module pdp_dot_acc_bench;
   localparam int VW = 128;
   localparam int OW = 256;
   localparam int NL = VW / 32;
   localparam int NE = VW / 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          sat_en = 1'b0;
   logic [VW-1:0] acc_in = '0;
   logic [VW-1:0] a_in = '0;
   logic [VW-1:0] b_in = '0;
   logic          out_valid;
   logic [OW-1:0] res_out;
   logic [NL-1:0] sat_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   pdp_dot_acc #(.VEC_W(VW), .OUT_W(OW)) u_pdp_dot_acc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .sat_en(sat_en), .acc_in(acc_in), .a_in(a_in), .b_in(b_in),
      .out_valid(out_valid), .res_out(res_out), .sat_flag(sat_flag)
   );

   function automatic longint ext16(logic [15:0] v, bit sg);
      if (sg) return longint'($signed(v));
      return longint'({48'b0, v});
   endfunction

   function automatic logic [31:0] ref_lane(input logic [1:0] m, input logic s,
                                            input logic [31:0] acc,
                                            input logic [15:0] a0, input logic [15:0] a1,
                                            input logic [15:0] b0, input logic [15:0] b1,
                                            output logic f);
      longint sum, accx;
      bit as, bs, uu;
      f  = 1'b0;
      as = (m == 2'b00);
      bs = (m == 2'b01);
      uu = (m == 2'b10);
      if (m == 2'b11) return 32'h0;
      accx = uu ? longint'({32'b0, acc}) : longint'($signed(acc));
      sum  = accx + ext16(a0, as) * ext16(b0, bs) + ext16(a1, as) * ext16(b1, bs);
      if (s) begin
         if (uu) begin
            if (sum > 64'sh0000_0000_FFFF_FFFF) begin f = 1'b1; return 32'hFFFF_FFFF; end
         end else begin
            if (sum > 64'sd2147483647)  begin f = 1'b1; return 32'h7FFF_FFFF; end
            if (sum < -64'sd2147483648) begin f = 1'b1; return 32'h8000_0000; end
         end
      end
      return sum[31:0];
   endfunction

   function automatic logic [OW-1:0] ref_vec(input logic [1:0] m, input logic s,
                                             input logic [VW-1:0] acc,
                                             input logic [VW-1:0] a, input logic [VW-1:0] b,
                                             output logic [NL-1:0] fl);
      logic [OW-1:0] r;
      logic f;
      r = '0;
      for (int j = 0; j < NL; j++) begin
         r[32*j +: 32] = ref_lane(m, s, acc[32*j +: 32], a[32*j +: 16], a[32*j+16 +: 16],
                                  b[32*j +: 16], b[32*j+16 +: 16], f);
         fl[j] = f;
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at a falling edge; the result is due after one rising edge.
   task automatic run_op(input string req, input logic [1:0] m, input logic s,
                         input logic [VW-1:0] acc, input logic [VW-1:0] a, input logic [VW-1:0] b);
      logic [OW-1:0] er;
      logic [NL-1:0] ef;
      er = ref_vec(m, s, acc, a, b, ef);
      mode = m; sat_en = s; acc_in = acc; a_in = a; b_in = b; in_valid = 1'b1;
      @(negedge clk);
      chk({req, " valid"}, OW'(out_valid), OW'(1'b1));
      chk({req, " result"}, res_out, er);
      chk({req, " flags"}, OW'(sat_flag), OW'(ef));
      in_valid = 1'b0;
   endtask

   function automatic logic [VW-1:0] fill16(logic [15:0] v);
      logic [VW-1:0] r;
      for (int i = 0; i < NE; i++) r[16*i +: 16] = v;
      return r;
   endfunction

   function automatic logic [VW-1:0] fill32(logic [31:0] v);
      logic [VW-1:0] r;
      for (int i = 0; i < NL; i++) r[32*i +: 32] = v;
      return r;
   endfunction

   task automatic test_reset();
      chk("R11 reset valid", OW'(out_valid), OW'(1'b0));
      chk("R11 reset result", res_out, '0);
   endtask

   task automatic test_lane_map();
      logic [VW-1:0] acc, a, b;
      for (int i = 0; i < NE; i++) begin
         a[16*i +: 16] = 16'(i * 3 + 1);
         b[16*i +: 16] = 16'(i * 5 + 2);
      end
      for (int j = 0; j < NL; j++) acc[32*j +: 32] = 32'(j * 1000 + 7);
      run_op("R1 R4 lane map", 2'b10, 1'b0, acc, a, b);
      run_op("R10 upper zero", 2'b10, 1'b0, fill32(32'h1234_5678), fill16(16'hFFFF), fill16(16'h0101));
   endtask

   task automatic test_modes();
      run_op("R2 signed A", 2'b00, 1'b0, fill32(32'd10), fill16(16'hFFFF), fill16(16'h0002));
      run_op("R2 unsigned B", 2'b00, 1'b0, fill32(32'd0), fill16(16'h0003), fill16(16'hFFFF));
      run_op("R3 signed B", 2'b01, 1'b0, fill32(32'd5), fill16(16'hFFFF), fill16(16'hFFFF));
      run_op("R3 unsigned A", 2'b01, 1'b0, fill32(32'd0), fill16(16'h8000), fill16(16'h0004));
      run_op("R4 both unsigned", 2'b10, 1'b0, fill32(32'd1), fill16(16'h8000), fill16(16'h8000));
   endtask

   task automatic test_wrap();
      run_op("R5 wrap uu", 2'b10, 1'b0, fill32(32'hFFFF_FFFF), fill16(16'hFFFF), fill16(16'hFFFF));
      run_op("R5 wrap su", 2'b00, 1'b0, fill32(32'h8000_0000), fill16(16'h8000), fill16(16'hFFFF));
   endtask

   task automatic test_signed_sat();
      logic [VW-1:0] acc, a, b;
      acc = {32'h0000_0064, 32'h7FFF_FFF0, 32'h7FFF_FFFF, 32'h8000_0000};
      a   = {16'h0002, 16'h0002, 16'h0001, 16'h0000, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h8000};
      b   = {16'h0003, 16'h0003, 16'h0008, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
      run_op("R6 R8 signed clamp su", 2'b00, 1'b1, acc, a, b);
      run_op("R6 R8 signed clamp us", 2'b01, 1'b1, acc, b, a);
      run_op("R6 exact no clamp", 2'b00, 1'b1, fill32(32'h7FFF_0000), fill16(16'h8000), fill16(16'h0001));
   endtask

   task automatic test_unsigned_sat();
      logic [VW-1:0] acc, a, b;
      acc = {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000};
      a   = {16'h1000, 16'h1000, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
      b   = {16'h0010, 16'h0010, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
      run_op("R7 R8 unsigned clamp", 2'b10, 1'b1, acc, a, b);
   endtask

   task automatic test_reserved();
      run_op("R9 reserved mode", 2'b11, 1'b0, fill32(32'h1111_2222), fill16(16'h1234), fill16(16'h4321));
      run_op("R9 reserved sat", 2'b11, 1'b1, fill32(32'h7FFF_FFFF), fill16(16'h7FFF), fill16(16'hFFFF));
   endtask

   task automatic test_latency();
      logic [OW-1:0] e1, e2;
      logic [NL-1:0] f1, f2;
      e1 = ref_vec(2'b10, 1'b0, fill32(32'd1), fill16(16'd2), fill16(16'd3), f1);
      e2 = ref_vec(2'b00, 1'b0, fill32(32'd9), fill16(16'hFFFE), fill16(16'd4), f2);
      mode = 2'b10; sat_en = 1'b0; acc_in = fill32(32'd1); a_in = fill16(16'd2); b_in = fill16(16'd3);
      in_valid = 1'b1;
      @(negedge clk);
      chk("R11 first result", res_out, e1);
      mode = 2'b00; acc_in = fill32(32'd9); a_in = fill16(16'hFFFE); b_in = fill16(16'd4);
      @(negedge clk);
      chk("R11 second result", res_out, e2);
      chk("R11 second valid", OW'(out_valid), OW'(1'b1));
      in_valid = 1'b0;
      a_in = fill16(16'h5555);
      @(negedge clk);
      chk("R11 idle valid low", OW'(out_valid), OW'(1'b0));
      chk("R11 idle result held", res_out, e2);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R11 reset clears valid", OW'(out_valid), OW'(1'b0));
      chk("R11 reset clears result", res_out, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_lane_map();
      test_modes();
      test_wrap();
      test_signed_sat();
      test_unsigned_sat();
      test_reserved();
      test_latency();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule